// File: doc/BRIEF.md
# Bidirectional Three-Phase Rotator

This block is a small clocked Moore machine that rotates a single active line around three phase outputs. One control input advances the rotation in ascending order (phase 1, 2, 3, back to 1). A second control input turns it the other way (phase 3, 2, 1, back to 3). When neither control input is asserted, the active phase stays where it is. It moves at most one step per clock edge.

The advance input has fixed priority. When both inputs are high, the machine advances, so every input combination selects exactly one action. The outputs are decoded only from the registered state. They change only at a clock edge and never follow the control inputs inside a cycle. A synchronous reset returns the machine to phase 1.

Top module: `phase_rotator`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the next output is `z1_o`=1, `z2_o`=0, `z3_o`=0. Reset is synchronous, so raising `rst_i` between edges leaves the outputs unchanged until the next edge.
- R2: With `fwd_i`=1 and `rev_i`=0 at an edge, the active output moves up by one: z1 to z2, z2 to z3, z3 to z1.
- R3: With `fwd_i`=0 and `rev_i`=1 at an edge, the active output moves down by one: z1 to z3, z3 to z2, z2 to z1.
- R4: With both `fwd_i` and `rev_i` high at an edge, the step is the same as in R2.
- R5: With `fwd_i`=0 and `rev_i`=0 at an edge, the active output does not change.
- R6: Once the first reset has been applied, exactly one of `z1_o`, `z2_o` and `z3_o` is high in every cycle.
- R7: The outputs come only from registered state. Changing `fwd_i` or `rev_i` between clock edges does not change any output before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset to phase 1 |
| fwd_i | input | 1 | Step upward (has priority) |
| rev_i | input | 1 | Step downward when `fwd_i` is low |
| z1_o | output | 1 | Phase 1 active |
| z2_o | output | 1 | Phase 2 active |
| z3_o | output | 1 | Phase 3 active |

## Verification
The bench builds the block with its default parameters: three phases and a two-bit state. This is the only configuration the block has. With this setting, full wrap-around is reachable in both directions within four steps of reset. The bench also covers the priority case with both inputs high, hold runs, and reset applied from a phase other than phase 1. The input-independence checks change the control inputs between edges and sample the outputs before the next edge.

// File: rtl/phase_rot_pkg.sv
package phase_rot_pkg;
    localparam int PHASES  = 3;
    localparam int PHASE_W = $clog2(PHASES + 1);

    typedef enum logic [PHASE_W-1:0] {
        PH_ONE   = 2'd0,
        PH_TWO   = 2'd1,
        PH_THREE = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    typedef struct packed {
        phase_e phase;
    } rot_state_t;
endpackage

// File: rtl/phase_rot_dir.sv
module phase_rot_dir
    import phase_rot_pkg::*;
(
    input  logic fwd_i,
    input  logic rev_i,
    output dir_e dir_o
);
    always_comb begin
        if (fwd_i) begin
            dir_o = DIR_UP;
        end else if (rev_i) begin
            dir_o = DIR_DOWN;
        end else begin
            dir_o = DIR_HOLD;
        end
    end
endmodule

// File: rtl/phase_rot_fsm.sv
module phase_rot_fsm
    import phase_rot_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  dir_e   dir_i,
    output phase_e phase_o
);
    rot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_ONE: begin
                if (dir_i == DIR_UP)        st_d.phase = PH_TWO;
                else if (dir_i == DIR_DOWN) st_d.phase = PH_THREE;
            end
            PH_TWO: begin
                if (dir_i == DIR_UP)        st_d.phase = PH_THREE;
                else if (dir_i == DIR_DOWN) st_d.phase = PH_ONE;
            end
            PH_THREE: begin
                if (dir_i == DIR_UP)        st_d.phase = PH_ONE;
                else if (dir_i == DIR_DOWN) st_d.phase = PH_TWO;
            end
            default: st_d.phase = PH_ONE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.phase <= PH_ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

    // R5
    hold_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (dir_i == DIR_HOLD) |=> $stable(st_q));
endmodule

// File: rtl/phase_rot_outdec.sv
module phase_rot_outdec
    import phase_rot_pkg::*;
#(
    parameter int N = PHASES
) (
    input  phase_e       phase_i,
    output logic [N-1:0] z_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign z_o[i] = (phase_i == phase_e'(PHASE_W'(i)));
    end
endmodule

// File: rtl/phase_rotator.sv
module phase_rotator
    import phase_rot_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic fwd_i,
    input  logic rev_i,
    output logic z1_o,
    output logic z2_o,
    output logic z3_o
);
    dir_e              dir;
    phase_e            phase;
    logic [PHASES-1:0] zv;

    phase_rot_dir u_dir (
        .fwd_i (fwd_i),
        .rev_i (rev_i),
        .dir_o (dir)
    );

    phase_rot_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .dir_i   (dir),
        .phase_o (phase)
    );

    phase_rot_outdec #(.N(PHASES)) u_dec (
        .phase_i (phase),
        .z_o     (zv)
    );

    assign z1_o = zv[0];
    assign z2_o = zv[1];
    assign z3_o = zv[2];

    // R1
    reset_entry_chk: assert property (@(posedge clk_i)
        rst_i |=> (z1_o && !z2_o && !z3_o));

    // R2 (also R4 when both are high)
    step_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        fwd_i |=> (zv == {$past(zv[1:0]), $past(zv[2])}));

    // R3
    step_down_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!fwd_i && rev_i) |=> (zv == {$past(zv[0]), $past(zv[2:1])}));

    // R5
    hold_out_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!fwd_i && !rev_i) |=> $stable(zv));

    // R6
    one_active_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(zv) == 1);
endmodule

// File: tb/tb_phase_rotator.sv
module tb_phase_rotator;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fwd = 1'b0;
    logic rev = 1'b0;
    logic z1, z2, z3;
    int   n_cmp = 0;
    int   n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phase_rotator dut (
        .clk_i (clk),
        .rst_i (rst),
        .fwd_i (fwd),
        .rev_i (rev),
        .z1_o  (z1),
        .z2_o  (z2),
        .z3_o  (z3)
    );

    task automatic chk(input string req, input logic [2:0] exp);
        n_cmp++;
        if ({z3, z2, z1} !== exp) begin
            n_err++;
            $display("FAIL %s: got z3z2z1=%b expected %b", req, {z3, z2, z1}, exp);
        end
    endtask

    task automatic step(input logic f, input logic r, input logic rs);
        @(negedge clk);
        fwd = f;
        rev = r;
        rst = rs;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        step(1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R1 reset entry", 3'b001);
    endtask

    task automatic t_forward();
        t_reset();
        step(1'b1, 1'b0, 1'b0); chk("R2 up 1->2", 3'b010);
        step(1'b1, 1'b0, 1'b0); chk("R2 up 2->3", 3'b100);
        step(1'b1, 1'b0, 1'b0); chk("R2 up 3->1", 3'b001);
        step(1'b1, 1'b0, 1'b0); chk("R2 up again", 3'b010);
    endtask

    task automatic t_reverse();
        t_reset();
        step(1'b0, 1'b1, 1'b0); chk("R3 down 1->3", 3'b100);
        step(1'b0, 1'b1, 1'b0); chk("R3 down 3->2", 3'b010);
        step(1'b0, 1'b1, 1'b0); chk("R3 down 2->1", 3'b001);
        step(1'b0, 1'b1, 1'b0); chk("R3 down again", 3'b100);
    endtask

    task automatic t_priority();
        t_reset();
        step(1'b1, 1'b1, 1'b0); chk("R4 both 1->2", 3'b010);
        step(1'b1, 1'b1, 1'b0); chk("R4 both 2->3", 3'b100);
        step(1'b1, 1'b1, 1'b0); chk("R4 both 3->1", 3'b001);
    endtask

    task automatic t_hold();
        t_reset();
        step(1'b1, 1'b0, 1'b0); chk("R2 setup", 3'b010);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, 1'b0);
            chk("R5 hold", 3'b010);
        end
        step(1'b0, 1'b1, 1'b0); chk("R3 after hold", 3'b001);
        step(1'b0, 1'b0, 1'b0); chk("R5 hold at 1", 3'b001);
    endtask

    task automatic t_input_independence();
        t_reset();
        step(1'b1, 1'b0, 1'b0); chk("R7 setup", 3'b010);
        @(negedge clk);
        fwd = 1'b1; rev = 1'b0;
        #1 chk("R7 fwd mid-cycle", 3'b010);
        fwd = 1'b0; rev = 1'b1;
        #1 chk("R7 rev mid-cycle", 3'b010);
        @(posedge clk);
        #2 chk("R3 after edge", 3'b001);
        chk("R6 one active", 3'b001);
    endtask

    task automatic t_mid_reset();
        t_reset();
        step(1'b0, 1'b1, 1'b0); chk("R3 setup", 3'b100);
        @(negedge clk);
        rst = 1'b1; fwd = 1'b1; rev = 1'b0;
        #1 chk("R1 sync, no change before edge", 3'b100);
        @(posedge clk);
        #2 chk("R1 reset from phase 3", 3'b001);
        step(1'b1, 1'b0, 1'b0); chk("R2 after reset", 3'b010);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_forward();
        t_reverse();
        t_priority();
        t_hold();
        t_input_independence();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule